// File: doc/BRIEF.md
# Pin Interrupt and DMA Event Detector

This block watches a bank of external pin inputs and raises a sticky status flag for each pin when that pin shows the condition its mode selects. The modes cover a level (low or high) or an edge (rising, falling or either) for interrupt use, and an edge for DMA use. Raw pins pass through a multi-flop synchroniser into the bus clock domain. A pin that has its digital filter turned on is instead sampled from the filter's output, which is already in the bus clock domain. Detection compares the current sampled value with the value from the previous clock. It only runs on pins whose mux is in a digital mode and whose mode code is not off.

All flags of pins in interrupt modes are ORed onto one interrupt line. All flags of pins in DMA modes are ORed onto one DMA request. Software clears flags by writing ones to a flag-clear word. A DMA-complete pulse retires every DMA-mode flag at once. While the chip is in stop mode, a combinational wake output reports any enabled pin whose raw level already meets its condition.

Top module: `pin_event_detector`

## Requirements
- R1: While reset is asserted and on leaving it, `flags`, `irq` and `dma_req` are all zero.
- R2: With the default two-stage synchroniser, a change on a raw pin reaches `flags` on the third rising clock edge after the change. After only two edges the flag is still clear.
- R3: Edge modes use code 9 (interrupt, rising), code 10 (interrupt, falling) and code 11 (interrupt, either edge). Each sets only on its own edge.
- R4: Code 8 (interrupt, level low) and code 12 (interrupt, level high) set the flag while the level holds. A clear written while the level still holds leaves the flag set. Once the level is gone, a clear removes it.
- R5: A write with `flag_clr_we` high clears exactly the flags whose bit in `flag_clr_data` is 1. All other flags are unchanged.
- R6: When a set condition and a clear reach the same flag in the same cycle, the flag stays set.
- R7: `irq` is high exactly when at least one flag is set on a pin whose current mode is an interrupt mode (codes 8 to 12).
- R8: Codes 1, 2 and 3 are DMA on rising, falling and either edge. `dma_req` is high exactly when a flag is set on a pin in one of these modes. A `dma_done` pulse clears all DMA-mode flags and leaves interrupt-mode flags untouched.
- R9: A pin whose `pin_digital` bit is 0 never sets its flag, whatever its mode and input.
- R10: When `filt_en` is set for a pin, detection uses `filt_in` directly, with no synchroniser. A rising `filt_in` in rising mode sets the flag on the next clock edge.
- R11: `wake` is high, with no clock needed, only while `stop_mode` is high and some enabled digital pin's raw input meets its mode's condition against the last sampled value.
- R12: Code 0 and every code not listed above (4 to 7 and 13 to 15) act as disabled and never set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw pin levels |
| pin_digital | input | NPINS | 1 when the pin's mux selects a digital function |
| mode_cfg | input | NPINS*MODE_W | Per-pin mode code, pin p at bits [4p+3:4p] |
| filt_en | input | NPINS | Per-pin digital filter enable |
| filt_in | input | NPINS | Filtered pin levels, already in the bus domain |
| flag_clr_we | input | 1 | Flag-clear write strobe |
| flag_clr_data | input | NPINS | Write-one-to-clear mask |
| dma_done | input | 1 | DMA transfer complete pulse |
| stop_mode | input | 1 | Chip is in stop mode |
| flags | output | NPINS | Per-pin sticky status flags |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | Combined DMA request |
| wake | output | 1 | Asynchronous wake request |

## Verification
The hardest case to reach is a set condition and a clear landing on the same flag in the same clock. A held level makes this deterministic: the bench holds a high level on a level-high pin, writes a clear to it, and checks that the flag survives. It does the same for a DMA-complete pulse that arrives while interrupt flags are also set. Random phases then switch modes, filter selection and digital enables underneath live flags. A bench-side model built from the requirements checks every cycle, so mode changes that hit mid-edge and clears mixed with DMA completion are compared cycle by cycle.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
   localparam int MODE_BITS = 4;

   typedef enum logic [MODE_BITS-1:0] {
      MD_OFF        = 4'd0,
      MD_DMA_RISE   = 4'd1,
      MD_DMA_FALL   = 4'd2,
      MD_DMA_EITHER = 4'd3,
      MD_IRQ_LOW    = 4'd8,
      MD_IRQ_RISE   = 4'd9,
      MD_IRQ_FALL   = 4'd10,
      MD_IRQ_EITHER = 4'd11,
      MD_IRQ_HIGH   = 4'd12
   } pin_mode_e;

   function automatic logic mode_is_dma(input logic [MODE_BITS-1:0] m);
      return (m == MD_DMA_RISE) || (m == MD_DMA_FALL) || (m == MD_DMA_EITHER);
   endfunction

   function automatic logic mode_is_irq(input logic [MODE_BITS-1:0] m);
      return (m >= MD_IRQ_LOW) && (m <= MD_IRQ_HIGH);
   endfunction

   // condition check of current value against previous sampled value
   function automatic logic mode_hit(input logic [MODE_BITS-1:0] m,
                                     input logic cur, input logic prv);
      logic h;
      case (m)
         MD_DMA_RISE, MD_IRQ_RISE:     h = cur & ~prv;
         MD_DMA_FALL, MD_IRQ_FALL:     h = ~cur & prv;
         MD_DMA_EITHER, MD_IRQ_EITHER: h = cur ^ prv;
         MD_IRQ_LOW:                   h = ~cur;
         MD_IRQ_HIGH:                  h = cur;
         default:                      h = 1'b0;
      endcase
      return h;
   endfunction
endpackage

// File: rtl/pin_evt_sync.sv
module pin_evt_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) stg[k] <= '0;
            end else begin
               stg[0] <= d;
               for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
   import pin_evt_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sync_in,
   input  logic                 raw_in,
   input  logic                 filt_en,
   input  logic                 filt_in,
   input  logic                 digital,
   input  logic [MODE_BITS-1:0] mode,
   input  logic                 clr,
   input  logic                 dma_done,
   output logic                 flag,
   output logic                 irq_flag,
   output logic                 dma_flag,
   output logic                 wake_hit
);
   logic sample, prev_q, flag_q, is_dma, is_irq, active, set_now, wipe;

   assign sample  = filt_en ? filt_in : sync_in;
   assign is_dma  = mode_is_dma(mode);
   assign is_irq  = mode_is_irq(mode);
   assign active  = digital & (is_dma | is_irq);
   assign set_now = active & mode_hit(mode, sample, prev_q);
   assign wipe    = clr | (dma_done & is_dma);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= sample;
         flag_q <= set_now | (flag_q & ~wipe);   // set takes priority
      end
   end

   assign flag     = flag_q;
   assign irq_flag = flag_q & is_irq;
   assign dma_flag = flag_q & is_dma;
   assign wake_hit = active & mode_hit(mode, raw_in, prev_q);
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
   import pin_evt_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int MODE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPINS-1:0]        pin_in,
   input  logic [NPINS-1:0]        pin_digital,
   input  logic [NPINS*MODE_W-1:0] mode_cfg,
   input  logic [NPINS-1:0]        filt_en,
   input  logic [NPINS-1:0]        filt_in,
   input  logic                    flag_clr_we,
   input  logic [NPINS-1:0]        flag_clr_data,
   input  logic                    dma_done,
   input  logic                    stop_mode,
   output logic [NPINS-1:0]        flags,
   output logic                    irq,
   output logic                    dma_req,
   output logic                    wake
);
   generate
      if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
         $error("NPINS must be in 1..64");
      end
      if (MODE_W != MODE_BITS) begin : g_bad_modew
         $error("MODE_W must match the package mode width");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be in 0..4");
      end
   endgenerate

   logic [NPINS-1:0] pin_sync, irq_vec, dma_vec, wake_vec, clr_vec;

   assign clr_vec = flag_clr_we ? flag_clr_data : '0;

   pin_evt_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         pin_evt_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (pin_sync[p]),
            .raw_in   (pin_in[p]),
            .filt_en  (filt_en[p]),
            .filt_in  (filt_in[p]),
            .digital  (pin_digital[p]),
            .mode     (mode_cfg[p*MODE_W +: MODE_W]),
            .clr      (clr_vec[p]),
            .dma_done (dma_done),
            .flag     (flags[p]),
            .irq_flag (irq_vec[p]),
            .dma_flag (dma_vec[p]),
            .wake_hit (wake_vec[p])
         );
      end
   endgenerate

   assign irq     = |irq_vec;
   assign dma_req = |dma_vec;
   assign wake    = stop_mode & (|wake_vec);
endmodule

// File: rtl/pin_evt_chk.sv
module pin_evt_chk
   import pin_evt_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int MODE_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NPINS-1:0]        pin_digital,
   input logic [NPINS*MODE_W-1:0] mode_cfg,
   input logic                    flag_clr_we,
   input logic [NPINS-1:0]        flag_clr_data,
   input logic                    dma_done,
   input logic                    stop_mode,
   input logic [NPINS-1:0]        flags,
   input logic                    irq,
   input logic                    dma_req,
   input logic                    wake
);
   logic [NPINS-1:0] elig, dma_mask, wipe;

   always_comb begin
      for (int i = 0; i < NPINS; i++) begin
         elig[i]     = pin_digital[i] & (mode_is_dma(mode_cfg[i*MODE_W +: MODE_W]) |
                                         mode_is_irq(mode_cfg[i*MODE_W +: MODE_W]));
         dma_mask[i] = mode_is_dma(mode_cfg[i*MODE_W +: MODE_W]);
      end
      wipe = (flag_clr_we ? flag_clr_data : '0) | (dma_done ? dma_mask : '0);
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (flags == '0 && !irq && !dma_req)); // R1
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(flags) & ~$past(wipe) & ~flags) == '0));                                  // R5
   AST_SET_NEEDS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ~$past(flags) & ~$past(elig)) == '0));                                  // R9
   AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (flags != '0)); // R7
   AST_DMA_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) dma_req |-> (flags != '0)); // R8
   AST_WAKE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n) wake |-> stop_mode);    // R11
endmodule

bind pin_event_detector pin_evt_chk #(.NPINS(NPINS), .MODE_W(MODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_digital(pin_digital), .mode_cfg(mode_cfg),
   .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data), .dma_done(dma_done),
   .stop_mode(stop_mode), .flags(flags), .irq(irq), .dma_req(dma_req), .wake(wake)
);

// File: tb/pin_event_detector_test.sv
`timescale 1ns/1ps
module pin_event_detector_test;
   localparam int NP = 32;
   localparam int MW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0, pin_digital = '1, filt_en = '0, filt_in = '0;
   logic [NP-1:0] flag_clr_data = '0;
   logic [NP*MW-1:0] mode_cfg = '0;
   logic flag_clr_we = 1'b0, dma_done = 1'b0, stop_mode = 1'b0;
   logic [NP-1:0] flags;
   logic irq, dma_req, wake;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   pin_event_detector uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_digital(pin_digital),
      .mode_cfg(mode_cfg), .filt_en(filt_en), .filt_in(filt_in),
      .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data), .dma_done(dma_done),
      .stop_mode(stop_mode), .flags(flags), .irq(irq), .dma_req(dma_req), .wake(wake)
   );

   // expected behaviour derived from the mode table in the requirements
   function automatic logic f_dma(input logic [3:0] m); return m >= 4'd1 && m <= 4'd3; endfunction
   function automatic logic f_irq(input logic [3:0] m); return m >= 4'd8 && m <= 4'd12; endfunction
   function automatic logic f_cond(input logic [3:0] m, input logic c, input logic pv);
      case (m)
         4'd1, 4'd9:  return c && !pv;
         4'd2, 4'd10: return !c && pv;
         4'd3, 4'd11: return c != pv;
         4'd8:        return !c;
         4'd12:       return c;
         default:     return 1'b0;
      endcase
   endfunction

   logic [NP-1:0] m_s1, m_s2, m_prev, m_flag;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0;
      end else begin
         logic [NP-1:0] nf, np;
         for (int p = 0; p < NP; p++) begin
            logic [3:0] m;
            logic smp, en, hit, wp;
            m   = mode_cfg[p*MW +: MW];
            smp = filt_en[p] ? filt_in[p] : m_s2[p];
            en  = pin_digital[p] && (f_dma(m) || f_irq(m));
            hit = en && f_cond(m, smp, m_prev[p]);
            wp  = (flag_clr_we && flag_clr_data[p]) || (dma_done && f_dma(m));
            nf[p] = hit || (m_flag[p] && !wp);
            np[p] = smp;
         end
         m_flag <= nf; m_prev <= np; m_s1 <= pin_in; m_s2 <= m_s1;
      end
   end

   function automatic logic [2:0] exp_outs();
      logic i = 1'b0, d = 1'b0, w = 1'b0;
      for (int p = 0; p < NP; p++) begin
         logic [3:0] m;
         m = mode_cfg[p*MW +: MW];
         i |= m_flag[p] && f_irq(m);
         d |= m_flag[p] && f_dma(m);
         w |= pin_digital[p] && (f_dma(m) || f_irq(m)) && f_cond(m, pin_in[p], m_prev[p]);
      end
      return {i, d, w && stop_mode};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_mode(input int p, input logic [3:0] m);
      mode_cfg[p*MW +: MW] = m;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4242));
      tick(3);
      chk("R1 flags in reset", flags, 0);
      chk("R1 irq/dma in reset", {irq, dma_req}, 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 flags after reset", flags, 0);

      // R2 / R3: rising interrupt on pin 3
      set_mode(3, 4'd9); pin_in[3] = 1'b1;
      tick(2); chk("R2 not yet visible", flags[3], 0);
      tick(1); chk("R2 visible on third edge", flags[3], 1);
      chk("R7 irq follows flag", irq, 1);

      // R5: clear pin 3 and an idle bit 5
      flag_clr_we = 1'b1; flag_clr_data = 32'h28;
      tick(1); flag_clr_we = 1'b0; flag_clr_data = '0;
      chk("R5 clear by write-one", flags, 0);
      chk("R7 irq drops", irq, 0);

      // R4 / R6: level high on pin 4
      set_mode(4, 4'd12); pin_in[4] = 1'b1;
      tick(3); chk("R4 level sets", flags[4], 1);
      flag_clr_we = 1'b1; flag_clr_data = 32'h10;
      tick(1); flag_clr_we = 1'b0; flag_clr_data = '0;
      chk("R6 set wins over clear", flags[4], 1);
      pin_in[4] = 1'b0;
      tick(2);
      flag_clr_we = 1'b1; flag_clr_data = 32'h10;
      tick(1); flag_clr_we = 1'b0; flag_clr_data = '0;
      chk("R4 clear after level gone", flags[4], 0);

      // R3 / R8: falling interrupt on pin 3, rising DMA on pin 6
      set_mode(3, 4'd10); pin_in[3] = 1'b0;
      set_mode(6, 4'd1);  pin_in[6] = 1'b1;
      tick(3);
      chk("R3 falling edge sets", flags[3], 1);
      chk("R8 dma flag sets", flags[6], 1);
      chk("R8 dma_req and irq", {dma_req, irq}, 2'b11);
      dma_done = 1'b1;
      tick(1); dma_done = 1'b0;
      chk("R8 dma_done clears dma flag only", flags[6:3], 4'b0001);
      chk("R8 dma_req drops, irq holds", {dma_req, irq}, 2'b01);
      flag_clr_we = 1'b1; flag_clr_data = '1;
      tick(1); flag_clr_we = 1'b0; flag_clr_data = '0;

      // R9 / R12: non-digital pin and reserved code
      set_mode(7, 4'd9); pin_digital[7] = 1'b0; pin_in[7] = 1'b1;
      set_mode(8, 4'd13); pin_in[8] = 1'b1;
      tick(4);
      chk("R9 non-digital pin never sets", flags[7], 0);
      chk("R12 reserved code never sets", flags[8], 0);
      pin_in[7] = 1'b0; pin_in[8] = 1'b0;
      tick(4);
      chk("R9 R12 still clear after fall", flags[8:7], 0);

      // R10: filtered path, no synchroniser delay
      set_mode(9, 4'd9); filt_en[9] = 1'b1; filt_in[9] = 1'b1;
      tick(1); chk("R10 filtered rise sets next edge", flags[9], 1);

      // R11: combinational wake on level-low pin 10
      stop_mode = 1'b1; set_mode(10, 4'd8);
      #1 chk("R11 wake asserted in stop", wake, 1);
      stop_mode = 1'b0;
      #1 chk("R11 wake gated outside stop", wake, 0);
      set_mode(10, 4'd0);
      tick(1);

      // random phase against the bench model
      rst_n = 1'b0; tick(2);
      chk("R1 flags in second reset", flags, 0);
      rst_n = 1'b1;
      filt_en = '0; pin_digital = '1; mode_cfg = '0;
      for (int cyc = 0; cyc < 1500; cyc++) begin
         logic [2:0] e;
         @(negedge clk);
         e = exp_outs();
         chk("R3 flags vs model", flags, m_flag);
         chk("R7 irq vs model", irq, e[2]);
         chk("R8 dma_req vs model", dma_req, e[1]);
         chk("R11 wake vs model", wake, e[0]);
         if (cyc % 60 == 0) begin
            for (int p = 0; p < NP; p++) begin
               logic [3:0] codes [10] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd14};
               set_mode(p, codes[$urandom_range(9)]);
               pin_digital[p] = ($urandom_range(7) != 0);
               filt_en[p]     = ($urandom_range(7) == 0);
            end
         end
         pin_in        = pin_in ^ ($urandom() & $urandom());
         filt_in       = filt_in ^ ($urandom() & $urandom());
         flag_clr_we   = ($urandom_range(5) == 0);
         flag_clr_data = $urandom();
         dma_done      = ($urandom_range(7) == 0);
         stop_mode     = ($urandom_range(3) == 0);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule